// File: doc/BRIEF.md
# Zone Access History Table

This block remembers recent memory traffic at the granularity of fixed-size address zones. Every zone entry has a tag, one touched bit for each cache line in the zone, and two small counters: how many accesses the zone has seen, and how many of those went to a line that had already been touched. A replacement-decision unit next to a cache sends it one address per request. In return it learns whether the zone is being tracked, whether this exact line was seen before, and the zone's running access and reuse counts. The ratio of those counts is a measure of spatial reuse across the zone.

The table is set-associative. By default it has 16 sets of 12 ways, and each entry covers 256 lines of 64 bytes, or 16 KB. A lookup is evaluated in the cycle the request is presented. The response registers and the entry update are both written on the following clock edge, so back-to-back requests to the same zone always see each other's effects. When a set has no matching entry, the first empty way is used; if there is none, the least recently used way is used. The new entry starts with every line untouched and both counters at zero, and the current access is then applied to it as a first touch.

Top module: `zone_access_map`

## Requirements
- R1: The request address is split as follows. Bits [5:0] select the byte within a line and take no part in the lookup. Bits [13:6] select one of 256 lines in the zone. Bits [17:14] select the set. Bits [31:18] form the zone tag.
- R2: An access to a zone that is not held produces rsp_map_hit=0, rsp_reuse=0, rsp_acc_cnt=1 and rsp_reuse_cnt=0.
- R3: Each accepted request produces exactly one response with rsp_valid=1 on the clock edge that follows it. A later access to a held zone reports rsp_map_hit=1.
- R4: The first access to a line in a held zone reports rsp_reuse=0. It raises the access count by one and leaves the reuse count unchanged.
- R5: An access to a line already touched in a held zone reports rsp_reuse=1 and raises both counts by one. rsp_reuse is never 1 without rsp_map_hit.
- R6: With counter width 5, if either incremented count would equal 31, then both stored counts are halved (rounding down), and the halved values are the ones reported. A reported count is therefore never 31, and the reuse count never exceeds the access count.
- R7: A set holds 12 distinct zones. A 13th distinct zone mapped to a full set replaces the least recently used zone, and that replaced zone misses on its next access.
- R8: A hit refreshes a zone's recency, so a zone hit just before an allocation survives it.
- R9: Reset drives rsp_valid low and empties the table, so the first access after reset misses.
- R10: A cycle without req_valid gives rsp_valid=0 on the next edge and changes no entry.
- R11: Zones in different sets do not affect each other's entries or counts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | An access is presented this cycle |
| req_addr | input | ADDR_W (32) | Byte address of the access |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_map_hit | output | 1 | The zone was already held in the table |
| rsp_reuse | output | 1 | The accessed line had been touched before |
| rsp_acc_cnt | output | CNT_W (5) | Zone access count after this access |
| rsp_reuse_cnt | output | CNT_W (5) | Zone reuse count after this access |

## Verification
Every result (the valid flag, the hit and reuse flags, and both counts) is due exactly one clock edge after the request cycle. The bench drives each request on a falling edge, holds it for one cycle, and samples the response on the next falling edge. That lands one full rising edge after the request and half a period clear of it. Checks for idle cycles sample on the falling edge after a cycle with no request. This confirms that the responses stop and that a following access sees unchanged counts.

// File: rtl/zam_pkg.sv
package zam_pkg;
  localparam int ADDR_W_DEF     = 32;
  localparam int LINE_BYTES_DEF = 64;
  localparam int ZONE_LINES_DEF = 256;
  localparam int SETS_DEF       = 16;
  localparam int WAYS_DEF       = 12;
  localparam int CNT_W_DEF      = 5;
endpackage

// File: rtl/zam_cnt_sat.sv
module zam_cnt_sat #(
  parameter int CNT_W = 5
) (
  input  logic [CNT_W-1:0] acc_in,
  input  logic [CNT_W-1:0] reu_in,
  input  logic             inc_reu,
  output logic [CNT_W-1:0] acc_out,
  output logic [CNT_W-1:0] reu_out
);
  localparam logic [CNT_W-1:0] TOP = '1;

  logic [CNT_W-1:0] acc_inc, reu_inc;
  logic             shrink;

  assign acc_inc = acc_in + 1'b1;
  assign reu_inc = reu_in + CNT_W'(inc_reu);
  assign shrink  = (acc_inc == TOP) || (reu_inc == TOP);
  assign acc_out = shrink ? (acc_inc >> 1) : acc_inc;
  assign reu_out = shrink ? (reu_inc >> 1) : reu_inc;
endmodule

// File: rtl/zam_lru.sv
module zam_lru #(
  parameter int SETS = 16,
  parameter int WAYS = 12,
  localparam int IDX_W = (SETS > 1) ? $clog2(SETS) : 1,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] qry_set,
  output logic [WAY_W-1:0] lru_way,
  input  logic             upd_en,
  input  logic [IDX_W-1:0] upd_set,
  input  logic [WAY_W-1:0] upd_way
);
  logic [WAY_W-1:0] age_q [SETS][WAYS];
  logic [WAYS-1:0]  oldest_vec;

  always_comb begin
    lru_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      oldest_vec[w] = (age_q[qry_set][w] == WAY_W'(WAYS - 1));
      if (oldest_vec[w]) lru_way = WAY_W'(w);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          age_q[s][w] <= WAY_W'(w);
    end else if (upd_en) begin
      for (int w = 0; w < WAYS; w++) begin
        if (WAY_W'(w) == upd_way)
          age_q[upd_set][w] <= '0;
        else if (age_q[upd_set][w] < age_q[upd_set][upd_way])
          age_q[upd_set][w] <= age_q[upd_set][w] + 1'b1;
      end
    end
  end

  // R7
  single_oldest_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(oldest_vec) == 1);
endmodule

// File: rtl/zone_access_map.sv
module zone_access_map
  import zam_pkg::*;
#(
  parameter int ADDR_W     = ADDR_W_DEF,
  parameter int LINE_BYTES = LINE_BYTES_DEF,
  parameter int ZONE_LINES = ZONE_LINES_DEF,
  parameter int SETS       = SETS_DEF,
  parameter int WAYS       = WAYS_DEF,
  parameter int CNT_W      = CNT_W_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  output logic              rsp_map_hit,
  output logic              rsp_reuse,
  output logic [CNT_W-1:0]  rsp_acc_cnt,
  output logic [CNT_W-1:0]  rsp_reuse_cnt
);
  localparam int LOFF_W  = $clog2(LINE_BYTES);
  localparam int MOFF_W  = $clog2(ZONE_LINES);
  localparam int IDX_W   = (SETS > 1) ? $clog2(SETS) : 1;
  localparam int WAY_W   = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam int TAG_W   = ADDR_W - LOFF_W - MOFF_W - IDX_W;
  localparam int ENTRIES = SETS * WAYS;
  localparam int ENT_W   = $clog2(ENTRIES);

  logic [TAG_W-1:0]      tag_q [SETS][WAYS];
  logic [WAYS-1:0]       vld_q [SETS];
  logic [CNT_W-1:0]      acc_q [SETS][WAYS];
  logic [CNT_W-1:0]      reu_q [SETS][WAYS];
  logic [ZONE_LINES-1:0] map_q [ENTRIES];

  logic [MOFF_W-1:0]     a_off;
  logic [IDX_W-1:0]      a_set;
  logic [TAG_W-1:0]      a_tag;
  logic [WAYS-1:0]       hit_vec, inv_vec;
  logic [WAY_W-1:0]      hit_way, inv_way, lru_way, sel_way;
  logic                  is_hit, any_inv, line_seen;
  logic [ENT_W-1:0]      ent;
  logic [ZONE_LINES-1:0] old_map, new_map;
  logic [CNT_W-1:0]      old_acc, old_reu, nxt_acc, nxt_reu;

  assign a_off = req_addr[LOFF_W +: MOFF_W];
  assign a_set = req_addr[LOFF_W + MOFF_W +: IDX_W];
  assign a_tag = req_addr[ADDR_W-1 -: TAG_W];

  always_comb begin
    hit_way = '0;
    inv_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      hit_vec[w] = vld_q[a_set][w] && (tag_q[a_set][w] == a_tag);
      inv_vec[w] = !vld_q[a_set][w];
      if (hit_vec[w]) hit_way = WAY_W'(w);
      if (inv_vec[w]) inv_way = WAY_W'(w);
    end
  end

  assign is_hit  = |hit_vec;
  assign any_inv = |inv_vec;
  assign sel_way = is_hit ? hit_way : (any_inv ? inv_way : lru_way);
  assign ent     = ENT_W'(a_set) * ENT_W'(WAYS) + ENT_W'(sel_way);

  assign old_map   = is_hit ? map_q[ent] : '0;
  assign line_seen = old_map[a_off];
  assign new_map   = old_map | (ZONE_LINES'(1) << a_off);
  assign old_acc   = is_hit ? acc_q[a_set][sel_way] : '0;
  assign old_reu   = is_hit ? reu_q[a_set][sel_way] : '0;

  zam_cnt_sat #(.CNT_W(CNT_W)) u_cnt (
    .acc_in (old_acc),
    .reu_in (old_reu),
    .inc_reu(line_seen),
    .acc_out(nxt_acc),
    .reu_out(nxt_reu)
  );

  zam_lru #(.SETS(SETS), .WAYS(WAYS)) u_lru (
    .clk    (clk),
    .rst    (rst),
    .qry_set(a_set),
    .lru_way(lru_way),
    .upd_en (req_valid),
    .upd_set(a_set),
    .upd_way(sel_way)
  );

  // entry payload: no reset, written only on a request
  always_ff @(posedge clk) begin
    if (req_valid) begin
      tag_q[a_set][sel_way] <= a_tag;
      acc_q[a_set][sel_way] <= nxt_acc;
      reu_q[a_set][sel_way] <= nxt_reu;
      map_q[ent]            <= new_map;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
    end else if (req_valid) begin
      vld_q[a_set][sel_way] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid     <= 1'b0;
      rsp_map_hit   <= 1'b0;
      rsp_reuse     <= 1'b0;
      rsp_acc_cnt   <= '0;
      rsp_reuse_cnt <= '0;
    end else begin
      rsp_valid     <= req_valid;
      rsp_map_hit   <= req_valid && is_hit;
      rsp_reuse     <= req_valid && line_seen;
      rsp_acc_cnt   <= nxt_acc;
      rsp_reuse_cnt <= nxt_reu;
    end
  end

  // R3
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  // R10
  idle_no_rsp_chk: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);
  // R2
  miss_fresh_counts_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_map_hit) |-> (rsp_acc_cnt == CNT_W'(1) && rsp_reuse_cnt == '0 && !rsp_reuse));
  // R5
  reuse_needs_hit_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_reuse |-> rsp_map_hit);
  // R6
  no_top_count_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (rsp_acc_cnt != '1 && rsp_reuse_cnt != '1 && rsp_reuse_cnt <= rsp_acc_cnt));
endmodule

// File: tb/zone_access_map_tb.sv
module zone_access_map_tb_top;
  typedef struct packed {
    logic [31:0] addr;
    logic        hit;
    logic        reuse;
    logic [4:0]  acc;
    logic [4:0]  reu;
  } vec_t;

  // zone A: set 0 tag 1; zone B: set 1 tag 1; zone C: set 0 tag 2
  localparam int NVEC = 9;
  localparam vec_t VECS [NVEC] = '{
    '{32'h0004_0000, 1'b0, 1'b0, 5'd1, 5'd0},  // R2 A line0 miss
    '{32'h0004_0005, 1'b1, 1'b1, 5'd2, 5'd1},  // R1 byte offset ignored, R5
    '{32'h0004_0040, 1'b1, 1'b0, 5'd3, 5'd1},  // R4 A line1 first touch
    '{32'h0004_3FC0, 1'b1, 1'b0, 5'd4, 5'd1},  // R1 A line255
    '{32'h0004_0040, 1'b1, 1'b1, 5'd5, 5'd2},  // R5 A line1 again
    '{32'h0004_4000, 1'b0, 1'b0, 5'd1, 5'd0},  // R11 B miss
    '{32'h0004_3FC0, 1'b1, 1'b1, 5'd6, 5'd3},  // R11 A unaffected
    '{32'h0008_0000, 1'b0, 1'b0, 5'd1, 5'd0},  // R2 C same set miss
    '{32'h0004_0000, 1'b1, 1'b1, 5'd7, 5'd4}   // R11 A kept
  };

  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid;
  logic [31:0] req_addr;
  logic        rsp_valid, rsp_map_hit, rsp_reuse;
  logic [4:0]  rsp_acc_cnt, rsp_reuse_cnt;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  zone_access_map dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_map_hit(rsp_map_hit), .rsp_reuse(rsp_reuse),
    .rsp_acc_cnt(rsp_acc_cnt), .rsp_reuse_cnt(rsp_reuse_cnt)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic access(input logic [31:0] a);
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = a;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic expect_rsp(input string req, input bit h, input bit r,
                            input int acc, input int reu);
    chk({req, " valid"}, int'(rsp_valid), 1);
    chk({req, " hit"}, int'(rsp_map_hit), int'(h));
    chk({req, " reuse"}, int'(rsp_reuse), int'(r));
    chk({req, " acc"}, int'(rsp_acc_cnt), acc);
    chk({req, " reu"}, int'(rsp_reuse_cnt), reu);
  endtask

  function automatic logic [31:0] set3_zone(input int t);
    return (32'(t) << 18) | (32'd3 << 14);
  endfunction

  initial begin
    rst = 1'b1;
    req_valid = 1'b0;
    req_addr = '0;
    repeat (3) @(negedge clk);
    chk("R9 reset valid", int'(rsp_valid), 0);
    rst = 1'b0;

    for (int i = 0; i < NVEC; i++) begin
      access(VECS[i].addr);
      expect_rsp($sformatf("R3 vec%0d", i), VECS[i].hit, VECS[i].reuse,
                 int'(VECS[i].acc), int'(VECS[i].reu));
    end

    // R10: idle cycles give no response and leave zone A alone
    @(negedge clk);
    chk("R10 idle valid", int'(rsp_valid), 0);
    @(negedge clk);
    chk("R10 idle valid2", int'(rsp_valid), 0);
    access(32'h0004_0000);
    expect_rsp("R10 state kept", 1'b1, 1'b1, 8, 5);

    // R6: saturation in zone D (set 2 tag 1), line0 repeatedly
    access(32'h0004_8000);
    expect_rsp("R6 first", 1'b0, 1'b0, 1, 0);
    for (int k = 2; k <= 30; k++) begin
      access(32'h0004_8000);
      chk("R6 acc ramp", int'(rsp_acc_cnt), k);
      chk("R6 reu ramp", int'(rsp_reuse_cnt), k - 1);
    end
    access(32'h0004_8000);
    expect_rsp("R6 halve", 1'b1, 1'b1, 15, 15);
    access(32'h0004_8000);
    expect_rsp("R6 after halve", 1'b1, 1'b1, 16, 16);

    // R7 / R8: fill set 3 with twelve zones
    for (int t = 1; t <= 12; t++) begin
      access(set3_zone(t));
      chk("R7 fill miss", int'(rsp_map_hit), 0);
    end
    access(set3_zone(1));
    expect_rsp("R8 refresh hit", 1'b1, 1'b1, 2, 1);
    access(set3_zone(13));
    chk("R7 13th miss", int'(rsp_map_hit), 0);
    access(set3_zone(1));
    expect_rsp("R8 refreshed kept", 1'b1, 1'b1, 3, 2);
    access(set3_zone(2));
    expect_rsp("R7 lru evicted", 1'b0, 1'b0, 1, 0);
    access(set3_zone(13));
    expect_rsp("R7 newest kept", 1'b1, 1'b1, 2, 1);
    access(set3_zone(12));
    chk("R7 other kept", int'(rsp_map_hit), 1);

    // R9: reset empties the table
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R9 reset valid again", int'(rsp_valid), 0);
    rst = 1'b0;
    access(32'h0004_0000);
    expect_rsp("R9 miss after reset", 1'b0, 1'b0, 1, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule